// File: doc/BRIEF.md
# Ring Control, Flush and Interrupt Coalescing Registers

This block is the per-ring register file that a host uses to run one descriptor ring of a DMA-style engine. A 32-bit memory-mapped port gives access to the ring base addresses, an activate bit and a flush request, a flush-done status, the completion write pointer, and three request counters that clear when read. The descriptor fetch and completion writing datapaths sit outside this block. They report only through single-cycle event inputs.

Completion events advance the completion write pointer and feed an interrupt coalescer. The coalescer emits a message-signalled interrupt as a one-cycle request carrying a programmed 64-bit address and a 32-bit data word. It fires when enough completions are pending or when a countdown timer expires. Once it has fired, it stays silent until the host reads the completion write pointer. The same pointer read is also the host's half of the flush handshake. A flush forces the completion pointer back to zero.

Top module: `ringctl_top`

## Requirements
- R1: Offset 0x000 reads the constant 0x76303031, offset 0x00C reads the `desc_wptr` input, and any offset that is not mapped reads zero.
- R2: The descriptor base at 0x004 keeps write-data bits 27:0, and the completion base at 0x018 keeps bits 26:0. Both read back and drive `desc_base` and `cmpl_base`.
- R3: The control register at 0x034 uses bit 4 for activate (`ring_active`) and bit 5 for flush request (`ring_flush`). Both read back, and writing zero clears both.
- R4: The completion write pointer at 0x01C counts `cmpl_evt` pulses modulo 2^CPTR_W. While the flush bit is set, the pointer is zero and events are ignored.
- R5: Bit 0 of 0x038 (flush done) becomes 1 only after 0x01C has been read while the flush bit was already set. It reads 0 again as soon as the flush bit is cleared.
- R6: The counters at 0x020 (`req_recv` count), 0x028 (`req_sent` count) and 0x030 (outstanding, which is received minus sent with a floor of 0) return their value and clear when read. An event in the same cycle as the read counts toward the new value.
- R7: Interrupt address low/high at 0x03C/0x040 and interrupt data at 0x064 are read/write. They appear on `irq_addr` (high word in bits 63:32) and `irq_data`.
- R8: Interrupt control at 0x048 holds the timer value in bits 31:16, the enable in bit 15 and the threshold in bits 9:0 (a threshold of 0 acts as 1). When enabled and armed, `irq_valid` pulses for one cycle, one cycle after the pending completion count reaches the threshold. The pulse clears the pending count.
- R9: The timer loads the programmed value on a completion that arrives when none is pending, and then counts down once per cycle. Reaching zero with completions pending fires an interrupt even below the threshold.
- R10: After an interrupt, no further interrupt is issued until the host reads 0x01C. Any completions still pending then fire.
- R11: With the enable at 0, no interrupt is issued, but completions keep accumulating. Setting the enable then fires the interrupt for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects happen at the clock edge) |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the current offset |
| desc_wptr | input | CPTR_W | Descriptor write pointer reported by the fetch side |
| cmpl_evt | input | 1 | One completion written by the engine |
| req_recv | input | 1 | One request received |
| req_sent | input | 1 | One request transmitted |
| ring_active | output | 1 | Ring activate level |
| ring_flush | output | 1 | Ring flush request level |
| desc_base | output | DBASE_W | Descriptor ring base field |
| cmpl_base | output | CBASE_W | Completion ring base field |
| irq_valid | output | 1 | One-cycle interrupt write request |
| irq_addr | output | 64 | Interrupt write address |
| irq_data | output | 32 | Interrupt write data |

## Verification
The hardest state to reach is an interrupt that is due but held back because the coalescer is not armed. Reaching it needs a first interrupt, then further completions past the threshold with no pointer read, and only then the pointer read that releases the second interrupt. The directed scenarios chain these steps and count interrupt pulses at each stage. Each scenario first runs a flush handshake so that the pending count starts from a known zero. The timer path uses a threshold set above the number of completions sent, so only the countdown can cause the pulse. The bench checks both that no pulse arrives too early and that one pulse arrives afterwards.

// File: rtl/ringctl_pkg.sv
package ringctl_pkg;
   localparam logic [7:0] OFS_VER      = 8'h00;
   localparam logic [7:0] OFS_DBASE    = 8'h04;
   localparam logic [7:0] OFS_DWPTR    = 8'h0C;
   localparam logic [7:0] OFS_CBASE    = 8'h18;
   localparam logic [7:0] OFS_CWPTR    = 8'h1C;
   localparam logic [7:0] OFS_NRECV    = 8'h20;
   localparam logic [7:0] OFS_NSENT    = 8'h28;
   localparam logic [7:0] OFS_NOUT     = 8'h30;
   localparam logic [7:0] OFS_CTRL     = 8'h34;
   localparam logic [7:0] OFS_FDONE    = 8'h38;
   localparam logic [7:0] OFS_IADDR_LO = 8'h3C;
   localparam logic [7:0] OFS_IADDR_HI = 8'h40;
   localparam logic [7:0] OFS_ICTRL    = 8'h48;
   localparam logic [7:0] OFS_IDATA    = 8'h64;

   localparam int CTRL_ACT_BIT   = 4;
   localparam int CTRL_FLUSH_BIT = 5;
   localparam int THR_W          = 10;
   localparam int TMR_W          = 16;

   typedef struct packed {
      logic [TMR_W-1:0] tval;
      logic             en;
      logic [THR_W-1:0] thr;
   } ictrl_t;

   localparam int NUM_CNT = 3;
   typedef enum logic [1:0] {CNT_RECV = 2'd0, CNT_SENT = 2'd1, CNT_OUT = 2'd2} cnt_idx_e;
endpackage

// File: rtl/ringctl_rdclr_cnt.sv
module ringctl_rdclr_cnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   logic [W-1:0] cnt_q, base, nxt;

   always_comb begin
      base = clr ? '0 : cnt_q;
      nxt  = base;
      if (inc && !dec && base != CNT_MAX)
         nxt = base + 1'b1;
      else if (dec && !inc && base != '0)
         nxt = base - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt;

   assign cnt = cnt_q;
endmodule

// File: rtl/ringctl_flush_hs.sv
module ringctl_flush_hs (
   input  logic clk,
   input  logic rst_n,
   input  logic flush_req,
   input  logic ptr_rd,
   output logic done
);
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= flush_req & (seen_q | ptr_rd);

   assign done = flush_req & seen_q;
endmodule

// File: rtl/ringctl_irq_coal.sv
module ringctl_irq_coal #(
   parameter int TMR_W = 16,
   parameter int THR_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic             flush,
   input  logic             en,
   input  logic [THR_W-1:0] thr,
   input  logic [TMR_W-1:0] tval,
   input  logic             rearm,
   output logic             irq_pulse,
   output logic             pend_any
);
   localparam int             PEND_W   = THR_W + 1;
   localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

   logic [PEND_W-1:0] pend_q, thr_eff;
   logic [TMR_W-1:0]  tmr_q;
   logic              run_q, armed_q, pulse_q, fire;

   always_comb begin
      thr_eff = (thr == '0) ? PEND_W'(1) : PEND_W'(thr);
      fire    = en && armed_q && (pend_q != '0) &&
                ((pend_q >= thr_eff) || (run_q && tmr_q == '0));
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         pend_q  <= '0;
         tmr_q   <= '0;
         run_q   <= 1'b0;
         armed_q <= 1'b1;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= fire;
         if (flush) begin
            pend_q <= '0;
            run_q  <= 1'b0;
            tmr_q  <= tval;
         end else if (fire) begin
            pend_q <= PEND_W'(evt);
            run_q  <= evt;
            tmr_q  <= tval;
         end else begin
            if (evt && pend_q != PEND_MAX)
               pend_q <= pend_q + 1'b1;
            if (evt && pend_q == '0) begin
               tmr_q <= tval;
               run_q <= 1'b1;
            end else if (run_q && tmr_q != '0) begin
               tmr_q <= tmr_q - 1'b1;
            end
         end
         if (fire)       armed_q <= 1'b0;
         else if (rearm) armed_q <= 1'b1;
      end

   assign irq_pulse = pulse_q;
   assign pend_any  = (pend_q != '0);
endmodule

// File: rtl/ringctl_top.sv
module ringctl_top
   import ringctl_pkg::*;
#(
   parameter int          ADDR_W  = 8,
   parameter int          CPTR_W  = 10,
   parameter int          CNT_W   = 32,
   parameter int          DBASE_W = 28,
   parameter int          CBASE_W = 27,
   parameter logic [31:0] VERSION = 32'h7630_3031
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic [CPTR_W-1:0]  desc_wptr,
   input  logic               cmpl_evt,
   input  logic               req_recv,
   input  logic               req_sent,
   output logic               ring_active,
   output logic               ring_flush,
   output logic [DBASE_W-1:0] desc_base,
   output logic [CBASE_W-1:0] cmpl_base,
   output logic               irq_valid,
   output logic [63:0]        irq_addr,
   output logic [31:0]        irq_data
);
   initial begin : g_param_chk
      if (ADDR_W < 7 || CPTR_W < 1 || CPTR_W > 32 || CNT_W < 1 || CNT_W > 32 ||
          DBASE_W < 1 || DBASE_W > 32 || CBASE_W < 1 || CBASE_W > 32)
         $error("ringctl_top: parameter out of range");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic               act_q, flush_q, flush_done, irq_en, pend_any;
   logic [DBASE_W-1:0] dbase_q;
   logic [CBASE_W-1:0] cbase_q;
   logic [CPTR_W-1:0]  cptr;
   logic [31:0]        iaddr_lo_q, iaddr_hi_q, idata_q;
   ictrl_t             ictrl_q;
   logic               cwp_rd, ctrl_wr;
   logic [NUM_CNT-1:0] c_inc, c_dec, c_clr;
   logic [CNT_W-1:0]   cnt_val [NUM_CNT];
   logic [CNT_W-1:0]   recv_cnt;

   assign cwp_rd  = reg_rd && hit(reg_addr, OFS_CWPTR);
   assign ctrl_wr = reg_wr && hit(reg_addr, OFS_CTRL);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         act_q      <= 1'b0;
         flush_q    <= 1'b0;
         dbase_q    <= '0;
         cbase_q    <= '0;
         iaddr_lo_q <= '0;
         iaddr_hi_q <= '0;
         idata_q    <= '0;
         ictrl_q    <= '0;
      end else if (reg_wr) begin
         if (ctrl_wr) begin
            act_q   <= reg_wdata[CTRL_ACT_BIT];
            flush_q <= reg_wdata[CTRL_FLUSH_BIT];
         end
         if (hit(reg_addr, OFS_DBASE))    dbase_q    <= reg_wdata[DBASE_W-1:0];
         if (hit(reg_addr, OFS_CBASE))    cbase_q    <= reg_wdata[CBASE_W-1:0];
         if (hit(reg_addr, OFS_IADDR_LO)) iaddr_lo_q <= reg_wdata;
         if (hit(reg_addr, OFS_IADDR_HI)) iaddr_hi_q <= reg_wdata;
         if (hit(reg_addr, OFS_IDATA))    idata_q    <= reg_wdata;
         if (hit(reg_addr, OFS_ICTRL))
            ictrl_q <= '{tval: reg_wdata[31:16], en: reg_wdata[15], thr: reg_wdata[9:0]};
      end

   // completion write pointer: held at zero while a flush is requested
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
         cptr <= '0;
      else if ((ctrl_wr && reg_wdata[CTRL_FLUSH_BIT]) || (flush_q && !ctrl_wr))
         cptr <= '0;
      else if (cmpl_evt)
         cptr <= cptr + 1'b1;

   ringctl_flush_hs u_flush (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush_req(flush_q),
      .ptr_rd   (cwp_rd),
      .done     (flush_done)
   );

   assign c_inc = {req_recv, req_sent, req_recv};
   assign c_dec = {req_sent, 1'b0, 1'b0};
   assign c_clr = {reg_rd && hit(reg_addr, OFS_NOUT),
                   reg_rd && hit(reg_addr, OFS_NSENT),
                   reg_rd && hit(reg_addr, OFS_NRECV)};

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      ringctl_rdclr_cnt #(.W(CNT_W)) u_cnt (
         .clk  (clk),
         .rst_n(rst_n),
         .inc  (c_inc[i]),
         .dec  (c_dec[i]),
         .clr  (c_clr[i]),
         .cnt  (cnt_val[i])
      );
   end

   assign recv_cnt = cnt_val[CNT_RECV];
   assign irq_en   = ictrl_q.en;

   ringctl_irq_coal #(.TMR_W(TMR_W), .THR_W(THR_W)) u_coal (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (cmpl_evt && !flush_q),
      .flush    (flush_q),
      .en       (ictrl_q.en),
      .thr      (ictrl_q.thr),
      .tval     (ictrl_q.tval),
      .rearm    (cwp_rd),
      .irq_pulse(irq_valid),
      .pend_any (pend_any)
   );

   always_comb begin
      reg_rdata = '0;
      if      (hit(reg_addr, OFS_VER))      reg_rdata = VERSION;
      else if (hit(reg_addr, OFS_DBASE))    reg_rdata = 32'(dbase_q);
      else if (hit(reg_addr, OFS_DWPTR))    reg_rdata = 32'(desc_wptr);
      else if (hit(reg_addr, OFS_CBASE))    reg_rdata = 32'(cbase_q);
      else if (hit(reg_addr, OFS_CWPTR))    reg_rdata = 32'(cptr);
      else if (hit(reg_addr, OFS_NRECV))    reg_rdata = 32'(cnt_val[CNT_RECV]);
      else if (hit(reg_addr, OFS_NSENT))    reg_rdata = 32'(cnt_val[CNT_SENT]);
      else if (hit(reg_addr, OFS_NOUT))     reg_rdata = 32'(cnt_val[CNT_OUT]);
      else if (hit(reg_addr, OFS_CTRL))     reg_rdata = 32'({flush_q, act_q}) << CTRL_ACT_BIT;
      else if (hit(reg_addr, OFS_FDONE))    reg_rdata = {31'd0, flush_done};
      else if (hit(reg_addr, OFS_IADDR_LO)) reg_rdata = iaddr_lo_q;
      else if (hit(reg_addr, OFS_IADDR_HI)) reg_rdata = iaddr_hi_q;
      else if (hit(reg_addr, OFS_ICTRL))    reg_rdata = {ictrl_q.tval, ictrl_q.en, 5'd0, ictrl_q.thr};
      else if (hit(reg_addr, OFS_IDATA))    reg_rdata = idata_q;
   end

   assign ring_active = act_q;
   assign ring_flush  = flush_q;
   assign desc_base   = dbase_q;
   assign cmpl_base   = cbase_q;
   assign irq_addr    = {iaddr_hi_q, iaddr_lo_q};
   assign irq_data    = idata_q;
endmodule

// File: rtl/ringctl_chk.sv
module ringctl_chk #(
   parameter int ADDR_W = 8,
   parameter int CPTR_W = 10,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              req_recv,
   input logic              irq_valid,
   input logic              ring_flush,
   input logic              flush_done,
   input logic [CPTR_W-1:0] cptr,
   input logic [CNT_W-1:0]  recv_cnt,
   input logic              irq_en,
   input logic              pend_any
);
   logic rd_cwp, rd_recv;
   assign rd_cwp  = reg_rd && reg_addr == ADDR_W'(ringctl_pkg::OFS_CWPTR);
   assign rd_recv = reg_rd && reg_addr == ADDR_W'(ringctl_pkg::OFS_NRECV);

   assert_flush_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |-> ring_flush);

   assert_cptr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ring_flush |-> cptr == '0);

   assert_rdclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_recv && !req_recv) |=> recv_cnt == '0);

   assert_no_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !rd_cwp) |=> !irq_valid);

   assert_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> !irq_valid);

   assert_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> $past(pend_any));
endmodule

bind ringctl_top ringctl_chk #(.ADDR_W(ADDR_W), .CPTR_W(CPTR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .req_recv  (req_recv),
   .irq_valid (irq_valid),
   .ring_flush(ring_flush),
   .flush_done(flush_done),
   .cptr      (cptr),
   .recv_cnt  (recv_cnt),
   .irq_en    (irq_en),
   .pend_any  (pend_any)
);

// File: tb/ringctl_top_tb.sv
`timescale 1ns/1ps
module ringctl_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [9:0]  desc_wptr = '0;
   logic        cmpl_evt = 1'b0, req_recv = 1'b0, req_sent = 1'b0;
   logic        ring_active, ring_flush, irq_valid;
   logic [27:0] desc_base;
   logic [26:0] cmpl_base;
   logic [63:0] irq_addr, last_addr;
   logic [31:0] irq_data, last_data;
   int n_chk = 0, n_fail = 0, irq_cnt = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   ringctl_top u_dut (.*);

   always @(posedge clk) if (irq_valid) begin
      irq_cnt++;
      last_addr = irq_addr;
      last_data = irq_data;
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic evts(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); cmpl_evt = 1'b1;
         @(negedge clk); cmpl_evt = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_state();
      logic [31:0] d;
      wr(8'h34, 32'h30);
      rd(8'h1C, d);
      wr(8'h34, 32'h10);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(8'h00, d); chk("R1 version", d, 32'h76303031);
      rd(8'h44, d); chk("R1 unmapped", d, 0);
      rd(8'h34, d); chk("R3 ctrl reset", d, 0);
      rd(8'h1C, d); chk("R4 cptr reset", d, 0);
      chk("R8 irq idle at reset", irq_valid, 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      desc_wptr = 10'd5;
      rd(8'h0C, d); chk("R1 desc wptr", d, 5);
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, d); chk("R2 dbase read", d, 32'h0FFF_FFFF);
      chk("R2 dbase port", desc_base, 28'hFFF_FFFF);
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h18, d); chk("R2 cbase read", d, 32'h07FF_FFFF);
   endtask

   task automatic t_ctrl();
      logic [31:0] d;
      wr(8'h34, 32'h10);
      rd(8'h34, d); chk("R3 ctrl read", d, 32'h10);
      chk("R3 active port", ring_active, 1);
      wr(8'h34, 32'h0);
      chk("R3 zero deactivates", {ring_active, ring_flush}, 0);
   endtask

   task automatic t_counters();
      logic [31:0] d;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); req_recv = 1'b1;
         @(negedge clk); req_recv = 1'b0;
      end
      @(negedge clk); req_sent = 1'b1;
      @(negedge clk); req_sent = 1'b0;
      rd(8'h20, d); chk("R6 recv count", d, 3);
      rd(8'h20, d); chk("R6 recv cleared", d, 0);
      rd(8'h28, d); chk("R6 sent count", d, 1);
      rd(8'h30, d); chk("R6 outstanding", d, 2);
      rd(8'h30, d); chk("R6 outstanding cleared", d, 0);
      @(negedge clk); reg_rd = 1'b1; reg_addr = 8'h20; req_recv = 1'b1;
      @(negedge clk); reg_rd = 1'b0; req_recv = 1'b0;
      rd(8'h20, d); chk("R6 event during read kept", d, 1);
   endtask

   task automatic t_cptr();
      logic [31:0] d;
      evts(4);
      rd(8'h1C, d); chk("R4 cptr counts", d, 4);
   endtask

   task automatic t_flush();
      logic [31:0] d;
      wr(8'h34, 32'h30);
      chk("R3 flush port", ring_flush, 1);
      rd(8'h38, d); chk("R5 done low before ptr read", d, 0);
      evts(2);
      rd(8'h1C, d); chk("R4 cptr zero in flush", d, 0);
      rd(8'h38, d); chk("R5 done after ptr read", d, 1);
      wr(8'h34, 32'h10);
      rd(8'h38, d); chk("R5 done falls", d, 0);
      evts(1);
      rd(8'h1C, d); chk("R4 cptr restarts", d, 1);
   endtask

   task automatic t_thresh();
      int base;
      clear_state();
      wr(8'h3C, 32'h0000_1000);
      wr(8'h40, 32'h0000_00AB);
      wr(8'h64, 32'h55);
      wr(8'h48, 32'hFFFF_8003);
      base = irq_cnt;
      evts(2); idle(4);
      chk("R8 below threshold", irq_cnt - base, 0);
      evts(1); idle(4);
      chk("R8 threshold fires once", irq_cnt - base, 1);
      chk("R7 irq addr", last_addr, 64'hAB_0000_1000);
      chk("R7 irq data", last_data, 32'h55);
   endtask

   task automatic t_rearm();
      logic [31:0] d;
      int base = irq_cnt;
      evts(3); idle(5);
      chk("R10 held until ptr read", irq_cnt - base, 0);
      rd(8'h1C, d); idle(4);
      chk("R10 fires after ptr read", irq_cnt - base, 1);
   endtask

   task automatic t_timer();
      int base;
      clear_state();
      wr(8'h48, {16'd6, 1'b1, 5'd0, 10'd10});
      base = irq_cnt;
      evts(1); idle(3);
      chk("R9 timer not yet expired", irq_cnt - base, 0);
      idle(8);
      chk("R9 timer fires", irq_cnt - base, 1);
   endtask

   task automatic t_disabled();
      int base;
      clear_state();
      wr(8'h48, {16'hFFFF, 1'b0, 5'd0, 10'd1});
      base = irq_cnt;
      evts(2); idle(6);
      chk("R11 disabled no irq", irq_cnt - base, 0);
      wr(8'h48, {16'hFFFF, 1'b1, 5'd0, 10'd1});
      idle(4);
      chk("R11 enable fires pending", irq_cnt - base, 1);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_regs();
      t_ctrl();
      t_counters();
      t_cptr();
      t_flush();
      t_thresh();
      t_rearm();
      t_timer();
      t_disabled();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule